// File: doc/BRIEF.md
# Banked Cartridge Memory Controller

This block is a cartridge mapper placed between a 16-bit CPU address bus and a banked ROM and RAM. A CPU write anywhere in the lower half of the address space (0x0000 to 0x7FFF) stores no data. Instead, it programs a small set of control registers. Address bits 15:13 select the register.

The registers hold four things:
- a RAM enable flag,
- the low five bits of the ROM bank,
- a shared two-bit field that gives either ROM bank bits 6:5 or the RAM bank,
- a banking-mode bit that decides which of those two meanings the shared field has.

From these registers and the current CPU address, the block forms two physical addresses:
- a ROM address for the fixed window at 0x0000 to 0x3FFF and the switchable window at 0x4000 to 0x7FFF,
- a RAM address for the window at 0xA000 to 0xBFFF.

It also gates RAM writes, steers read data back to the CPU, and decodes the cartridge header's RAM-size code into a byte count. The ROM size is given as a code. A bank number beyond the ROM wraps around to a bank inside it.

Top module: `cart_mapper`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0, the mode is 0 and RAM is disabled, so reading 0x4000 gives ROM address 0x04000 and reading 0xA000 returns 0xFF.
- R2: A write to 0x0000-0x1FFF with data 0x0A enables RAM, data 0x00 disables it, and any other value leaves the enable unchanged.
- R3: A write to 0x2000-0x3FFF sets ROM bank bits 4:0 from data bits 4:0, replaces a zero there with 1, and keeps bank bits 6:5.
- R4: With mode 0, a write to 0x4000-0x5FFF sets ROM bank bits 6:5 from data bits 1:0.
- R5: With mode 1, a write to 0x4000-0x5FFF sets the RAM bank from data bits 1:0 and leaves the ROM bank unchanged.
- R6: A write to 0x6000-0x7FFF sets the mode from data bit 0; entering mode 1 clears ROM bank bits 6:5, and entering mode 0 sets the RAM bank to 0.
- R7: The switchable-window ROM bank is ANDed with (2^(code+1) - 1) for ROM size code 0..6 (2 to 128 banks of 16 KiB); code 7 uses all 7 bits.
- R8: CPU addresses 0x0000-0x3FFF always map to ROM address {7'd0, addr[13:0]}; addresses 0x4000-0x7FFF map to {bank, addr[13:0]}.
- R9: The RAM address is {ram_bank, addr[12:0]}. A CPU access to 0xA000-0xBFFF while RAM is disabled produces no RAM write strobe and returns 0xFF; while RAM is enabled it strobes writes and returns the RAM data.
- R10: The header RAM-size code decodes to 0 bytes for 0, 2048 for 1, 8192 for 2, 32768 for 3, and 8192 for any other code.
- R11: CPU writes at 0x8000 and above change no control register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| rom_size_code | input | 3 | ROM size as log2(banks)-1 |
| ram_size_code | input | 8 | Header RAM-size code |
| rom_rdata | input | 8 | Data from the ROM array |
| ram_rdata | input | 8 | Data from the RAM array |
| rom_addr | output | 21 | Physical ROM byte address |
| ram_addr | output | 15 | Physical RAM byte address |
| ram_we | output | 1 | RAM write strobe |
| ram_en | output | 1 | RAM enable flag |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| ram_bytes | output | 16 | Decoded RAM size in bytes |

## Verification
The hardest cases to reach through the ports need a particular order of register writes:
- The RAM bank is set while in mode 1, and then the mode is switched back to 0.
- The upper ROM bits are set in mode 0, and then mode 1 is entered.
- A bank is selected that is larger than a small ROM, so it must wrap.

Directed sequences reach each of these orders. A long run of seeded random writes covers all four register regions, the writes above 0x8000 that should have no effect, and every ROM size code. After each write, the ROM window, the RAM window and the read data are compared against a reference model kept in the bench.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
    parameter int BANK_W     = 7;
    parameter int LO_W       = 5;
    parameter int SHARED_W   = 2;
    parameter int ROM_OFF_W  = 14;
    parameter int RAM_OFF_W  = 13;
    parameter int SIZE_W     = 16;
    localparam int ROM_ADDR_W = BANK_W + ROM_OFF_W;
    localparam int RAM_ADDR_W = SHARED_W + RAM_OFF_W;

    typedef enum logic [1:0] {
        REG_ENABLE = 2'd0,
        REG_LOBANK = 2'd1,
        REG_SHARED = 2'd2,
        REG_MODE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic                ram_on;
        logic                mode;
        logic [SHARED_W-1:0] rom_hi;
        logic [LO_W-1:0]     rom_lo;
        logic [SHARED_W-1:0] ram_bank;
    } ctrl_t;

    function automatic logic [BANK_W-1:0] bank_mask(input logic [2:0] code);
        logic [BANK_W-1:0] m;
        for (int i = 0; i < BANK_W; i++)
            m[i] = (i <= int'(code));
        return m;
    endfunction

    function automatic logic [SIZE_W-1:0] ram_size_of(input logic [7:0] code);
        case (code)
            8'd0:    return SIZE_W'(0);
            8'd1:    return SIZE_W'(16'h0800);
            8'd3:    return SIZE_W'(16'h8000);
            default: return SIZE_W'(16'h2000);
        endcase
    endfunction
endpackage

// File: rtl/cart_map_regs.sv
module cart_map_regs
    import cart_map_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    output ctrl_t       ctrl
);
    logic     hit;
    reg_sel_e sel;
    logic [LO_W-1:0] lo_val;

    assign hit    = wr && !addr[15];
    assign sel    = reg_sel_e'(addr[14:13]);
    assign lo_val = (wdata[LO_W-1:0] == '0) ? LO_W'(1) : wdata[LO_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.ram_on   <= 1'b0;
            ctrl.mode     <= 1'b0;
            ctrl.rom_hi   <= '0;
            ctrl.rom_lo   <= LO_W'(1);
            ctrl.ram_bank <= '0;
        end else if (hit) begin
            case (sel)
                REG_ENABLE: begin
                    if (wdata == 8'h0A)      ctrl.ram_on <= 1'b1;
                    else if (wdata == 8'h00) ctrl.ram_on <= 1'b0;
                end
                REG_LOBANK: ctrl.rom_lo <= lo_val;
                REG_SHARED: begin
                    if (ctrl.mode) ctrl.ram_bank <= wdata[SHARED_W-1:0];
                    else           ctrl.rom_hi   <= wdata[SHARED_W-1:0];
                end
                REG_MODE: begin
                    ctrl.mode <= wdata[0];
                    if (wdata[0]) ctrl.rom_hi   <= '0;
                    else          ctrl.ram_bank <= '0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cart_map_xlate.sv
module cart_map_xlate
    import cart_map_pkg::*;
(
    input  ctrl_t                 ctrl,
    input  logic [15:0]           addr,
    input  logic                  wr,
    input  logic [2:0]            size_code,
    input  logic [7:0]            rom_rdata,
    input  logic [7:0]            ram_rdata,
    output logic [ROM_ADDR_W-1:0] rom_addr,
    output logic [RAM_ADDR_W-1:0] ram_addr,
    output logic                  ram_we,
    output logic [7:0]            rdata
);
    logic [BANK_W-1:0] raw_bank;
    logic [BANK_W-1:0] eff_bank;
    logic              in_ram_win;

    assign raw_bank   = {ctrl.rom_hi, ctrl.rom_lo};
    assign eff_bank   = raw_bank & bank_mask(size_code);
    assign in_ram_win = (addr[15:13] == 3'b101);

    always_comb begin
        if (addr[15:14] == 2'b00)
            rom_addr = {{BANK_W{1'b0}}, addr[ROM_OFF_W-1:0]};
        else
            rom_addr = {eff_bank, addr[ROM_OFF_W-1:0]};
    end

    assign ram_addr = {ctrl.ram_bank, addr[RAM_OFF_W-1:0]};
    assign ram_we   = wr && in_ram_win && ctrl.ram_on;

    always_comb begin
        if (!addr[15])                     rdata = rom_rdata;
        else if (in_ram_win && ctrl.ram_on) rdata = ram_rdata;
        else                               rdata = 8'hFF;
    end
endmodule

// File: rtl/cart_map_sizedec.sv
module cart_map_sizedec
    import cart_map_pkg::*;
(
    input  logic [7:0]        code,
    output logic [SIZE_W-1:0] bytes_o
);
    assign bytes_o = ram_size_of(code);
endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
    import cart_map_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [15:0]           cpu_addr,
    input  logic [7:0]            cpu_wdata,
    input  logic                  cpu_wr,
    input  logic [2:0]            rom_size_code,
    input  logic [7:0]            ram_size_code,
    input  logic [7:0]            rom_rdata,
    input  logic [7:0]            ram_rdata,
    output logic [ROM_ADDR_W-1:0] rom_addr,
    output logic [RAM_ADDR_W-1:0] ram_addr,
    output logic                  ram_we,
    output logic                  ram_en,
    output logic [7:0]            cpu_rdata,
    output logic [SIZE_W-1:0]     ram_bytes
);
    ctrl_t ctrl;

    cart_map_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (cpu_wr),
        .addr  (cpu_addr),
        .wdata (cpu_wdata),
        .ctrl  (ctrl)
    );

    cart_map_xlate u_xlate (
        .ctrl      (ctrl),
        .addr      (cpu_addr),
        .wr        (cpu_wr),
        .size_code (rom_size_code),
        .rom_rdata (rom_rdata),
        .ram_rdata (ram_rdata),
        .rom_addr  (rom_addr),
        .ram_addr  (ram_addr),
        .ram_we    (ram_we),
        .rdata     (cpu_rdata)
    );

    cart_map_sizedec u_size (
        .code    (ram_size_code),
        .bytes_o (ram_bytes)
    );

    assign ram_en = ctrl.ram_on;
endmodule

// File: rtl/cart_mapper_checker.sv
module cart_mapper_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        cpu_wr,
    input logic [7:0]  ram_rdata,
    input logic [20:0] rom_addr,
    input logic        ram_we,
    input logic        ram_en,
    input logic [7:0]  cpu_rdata
);
    // R2
    a_r2_enable: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15:13] == 3'd0 && cpu_wdata == 8'h0A) |=> ram_en);
    a_r2_disable: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15:13] == 3'd0 && cpu_wdata == 8'h00) |=> !ram_en);
    a_r2_other_keeps: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15:13] == 3'd0 && cpu_wdata != 8'h00 && cpu_wdata != 8'h0A)
        |=> $stable(ram_en));
    // R11
    a_r11_high_write_inert: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15]) |=> $stable(ram_en));
    // R8
    a_r8_fixed_window: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:14] == 2'b00) |-> (rom_addr[20:14] == 7'd0));
    // R9
    a_r9_no_strobe_disabled: assert property (@(posedge clk) disable iff (rst)
        !ram_en |-> !ram_we);
    a_r9_ff_when_disabled: assert property (@(posedge clk) disable iff (rst)
        (!ram_en && cpu_addr[15:13] == 3'b101) |-> (cpu_rdata == 8'hFF));
    a_r9_data_when_enabled: assert property (@(posedge clk) disable iff (rst)
        (ram_en && cpu_addr[15:13] == 3'b101) |-> (cpu_rdata == ram_rdata));
endmodule

bind cart_mapper cart_mapper_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_wr    (cpu_wr),
    .ram_rdata (ram_rdata),
    .rom_addr  (rom_addr),
    .ram_we    (ram_we),
    .ram_en    (ram_en),
    .cpu_rdata (cpu_rdata)
);

// File: tb/cart_mapper_test.sv
module cart_mapper_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0;
    logic [7:0]  cpu_wdata = 8'h0;
    logic        cpu_wr = 1'b0;
    logic [2:0]  rom_size_code = 3'd6;
    logic [7:0]  ram_size_code = 8'd0;
    logic [7:0]  rom_rdata = 8'h5A;
    logic [7:0]  ram_rdata = 8'hC3;
    logic [20:0] rom_addr;
    logic [14:0] ram_addr;
    logic        ram_we;
    logic        ram_en;
    logic [7:0]  cpu_rdata;
    logic [15:0] ram_bytes;

    int checks = 0;
    int fails  = 0;

    // reference model
    logic [4:0] m_lo = 5'd1;
    logic [1:0] m_hi = 2'd0;
    logic [1:0] m_rb = 2'd0;
    logic       m_mode = 1'b0;
    logic       m_en = 1'b0;

    always #5 clk = ~clk;

    cart_mapper uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .rom_size_code(rom_size_code), .ram_size_code(ram_size_code),
        .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .rom_addr(rom_addr),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_en(ram_en),
        .cpu_rdata(cpu_rdata), .ram_bytes(ram_bytes)
    );

    function automatic logic [20:0] exp_rom(input logic [15:0] a);
        logic [6:0] mask;
        mask = (rom_size_code >= 3'd6) ? 7'h7F : 7'((2 << rom_size_code) - 1);
        if (a < 16'h4000) return {7'd0, a[13:0]};
        return {({m_hi, m_lo} & mask), a[13:0]};
    endfunction

    function automatic logic [15:0] exp_size(input logic [7:0] c);
        if (c == 8'd0) return 16'd0;
        if (c == 8'd1) return 16'd2048;
        if (c == 8'd3) return 16'd32768;
        return 16'd8192;
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [15:0] a);
        if (a < 16'h8000) return rom_rdata;
        if (a >= 16'hA000 && a < 16'hC000 && m_en) return ram_rdata;
        return 8'hFF;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        if (a[15]) return;
        case (a[14:13])
            2'd0: if (d == 8'h0A) m_en = 1'b1; else if (d == 8'h00) m_en = 1'b0;
            2'd1: m_lo = (d[4:0] == 5'd0) ? 5'd1 : d[4:0];
            2'd2: if (m_mode) m_rb = d[1:0]; else m_hi = d[1:0];
            default: begin
                m_mode = d[0];
                if (d[0]) m_hi = 2'd0; else m_rb = 2'd0;
            end
        endcase
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        #1;
        if (a >= 16'hA000 && a < 16'hC000) check("R9 write strobe", 32'(ram_we), 32'(m_en));
        @(posedge clk);
        model_write(a, d);
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic probe(input logic [15:0] rom_a, input logic [15:0] ram_a);
        cpu_addr = rom_a; #1;
        check("R3 R4 R7 R8 rom_addr", 32'(rom_addr), 32'(exp_rom(rom_a)));
        check("R8 rom rdata", 32'(cpu_rdata), 32'(exp_rdata(rom_a)));
        cpu_addr = ram_a; #1;
        check("R5 R6 R9 ram_addr", 32'(ram_addr), {17'd0, m_rb, ram_a[12:0]});
        check("R9 ram rdata", 32'(cpu_rdata), 32'(exp_rdata(ram_a)));
        check("R2 ram_en", 32'(ram_en), 32'(m_en));
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        cpu_addr = 16'h4000; #1;
        check("R1 reset bank", 32'(rom_addr), 32'h04000);
        cpu_addr = 16'hA000; #1;
        check("R1 reset ram read", 32'(cpu_rdata), 32'hFF);
        check("R1 reset ram_en", 32'(ram_en), 32'd0);
        // R10
        foreach (uut.ram_bytes[i]) ; 
        for (int c = 0; c < 6; c++) begin
            ram_size_code = (c == 5) ? 8'hFF : 8'(c); #1;
            check("R10 ram size", 32'(ram_bytes), 32'(exp_size(ram_size_code)));
        end
        // R2
        wr(16'h0000, 8'h0A); probe(16'h4123, 16'hA010);
        wr(16'h1FFF, 8'h55); probe(16'h4123, 16'hA010);
        wr(16'h0100, 8'h00); probe(16'h4123, 16'hA010);
        wr(16'h0100, 8'h0A);
        // R3 zero maps to 1, hi kept
        wr(16'h4000, 8'h03); wr(16'h2000, 8'h00); probe(16'h7FFF, 16'hBFFF);
        wr(16'h2000, 8'hE0); probe(16'h4000, 16'hA000);
        wr(16'h3FFF, 8'h1F); probe(16'h5555, 16'hA555);
        // R6 mode 1 clears hi; R5 ram bank
        wr(16'h6000, 8'h01); probe(16'h4000, 16'hA000);
        wr(16'h4000, 8'h02); probe(16'h4000, 16'hBABC);
        // R6 mode 0 clears ram bank
        wr(16'h7000, 8'h00); probe(16'h4000, 16'hBABC);
        // R7 wrap
        wr(16'h4000, 8'h03); wr(16'h2000, 8'h05);
        for (int c = 0; c < 8; c++) begin
            rom_size_code = 3'(c); probe(16'h6ABC, 16'hA001);
        end
        // R11 high writes inert
        wr(16'hA123, 8'h00); wr(16'hC000, 8'h00); wr(16'hFFFF, 8'h01);
        probe(16'h4001, 16'hA123);
        // random
        for (int n = 0; n < 600; n++) begin
            logic [15:0] a;
            logic [7:0]  d;
            a = 16'($urandom);
            d = ($urandom % 4 == 0) ? (($urandom % 2) ? 8'h0A : 8'h00) : 8'($urandom);
            rom_size_code = 3'($urandom);
            rom_rdata = 8'($urandom);
            ram_rdata = 8'($urandom);
            wr(a, d);
            probe({2'b01, 14'($urandom)}, {3'b101, 13'($urandom)});
            cpu_addr = 16'($urandom); #1;
            check("R8 R9 R11 rdata", 32'(cpu_rdata), 32'(exp_rdata(cpu_addr)));
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule